// File: doc/BRIEF.md
# Programmable Feedback Divider with Phased Sync Pulse

This block divides a fast oscillator clock by a programmable modulus and marks each divide period with a one-clock terminal-count strobe. It also drives a sync pulse level whose rising and falling positions inside the period are programmed in steps of eight clocks. The block compares each pulse setting with the upper eight bits of the period counter. This lets a loop designer shift the phase of the divided signal without changing its frequency.

All settings arrive as parallel inputs. The block samples them only at the end of a period, so a period is never cut short or reshaped partway through. A divider setting that is too small, or a pulse position that falls outside the period, is caught when it is sampled. Such a fault raises an error flag that stays set until reset.

Top module: `fbdiv_top`

## Requirements
- R1: The period counter runs from 0 up to the active divider setting and then returns to 0, so the modulus is the setting plus one. `tc_o` is high for exactly the one clock in which the counter holds the setting.
- R2: While `rst` is high, `tc_o`, `sync_o` and `err_o` are low and the counter holds 0. The first period after release uses divider 0x04F (modulus 80), pulse start 3 and pulse end 6, and its strobe appears 79 clocks after release.
- R3: A divider input below 63, sampled at the end of a period, is rejected: the previous modulus stays in force and `err_o` goes high.
- R4: The divider, start and end inputs are sampled only in the clock where `tc_o` is high. Changes at any other time have no effect on the current period.
- R5: With end above start, `sync_o` is high while the count lies in the range from start×8 to end×8−1 (start×8 included, end×8 excluded).
- R6: With end below start, the pulse spans the period boundary. `sync_o` rises at count start×8, stays high through the strobe, and falls at count end×8 of the next period.
- R7: With end equal to start, the rise takes priority at that count, so once `sync_o` has risen it stays high for as long as the setting holds.
- R8: If either pulse setting is not below bits 10:3 of the active divider setting, `sync_o` is low for that whole period and `err_o` goes high.
- R9: `err_o` stays high once set, until `rst`.
- R10: Both ends of the divider range work: setting 63 (modulus 64) and setting 2047 (modulus 2048), with pulse positions up to one step below the upper-bit limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| div_set | input | 11 | Divider setting (modulus = value + 1) |
| rise_set | input | 8 | Pulse start position, in eight-clock steps |
| fall_set | input | 8 | Pulse end position, in eight-clock steps |
| tc_o | output | 1 | One-clock terminal-count strobe |
| sync_o | output | 1 | Phased sync pulse level |
| err_o | output | 1 | Sticky invalid-setting flag |

## Verification
A wrong count or a wrong active modulus shows up at the next strobe. The strobe arrives early or late, and within one period the edges of `sync_o` shift along with it. A shadow setting loaded at the wrong time leaves the strobe spacing correct until the next boundary, so the bench changes the inputs on every clock during one phase to expose such a fault. A bad pulse-enable decision shows within eight clocks of the expected rising edge. A flag that fails to hold shows in the first valid period after a fault.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    parameter int CNT_W   = 11;
    parameter int PHS_W   = 8;
    parameter int STEP_LG = CNT_W - PHS_W;
    parameter int MIN_SET = 63;

    parameter logic [CNT_W-1:0] DEF_DIV  = 11'h04F;
    parameter logic [PHS_W-1:0] DEF_RISE = 8'h03;
    parameter logic [PHS_W-1:0] DEF_FALL = 8'h06;

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [PHS_W-1:0] rise;
        logic [PHS_W-1:0] fall;
        logic             pen;
    } cfg_t;

    parameter cfg_t CFG_RST = '{div: DEF_DIV, rise: DEF_RISE, fall: DEF_FALL, pen: 1'b1};

    function automatic logic [CNT_W-1:0] edge_pos(input logic [PHS_W-1:0] p);
        return {p, {STEP_LG{1'b0}}};
    endfunction

    function automatic logic div_ok(input logic [CNT_W-1:0] d);
        return d >= CNT_W'(MIN_SET);
    endfunction

    function automatic cfg_t screen(input logic [CNT_W-1:0] d_in,
                                    input logic [PHS_W-1:0] r_in,
                                    input logic [PHS_W-1:0] f_in,
                                    input logic [CNT_W-1:0] d_cur);
        cfg_t c;
        logic [PHS_W-1:0] top;
        c.div  = div_ok(d_in) ? d_in : d_cur;
        c.rise = r_in;
        c.fall = f_in;
        top    = c.div[CNT_W-1:STEP_LG];
        c.pen  = (r_in < top) && (f_in < top);
        return c;
    endfunction

endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
    import fbdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic [CNT_W-1:0] div_in,
    input  logic [PHS_W-1:0] rise_in,
    input  logic [PHS_W-1:0] fall_in,
    output cfg_t             act,
    output cfg_t             nxt,
    output logic             err
);

    cfg_t cand;
    logic fault;

    always_comb begin
        cand  = screen(div_in, rise_in, fall_in, act.div);
        fault = !div_ok(div_in) || !cand.pen;
        nxt   = wrap ? cand : act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= CFG_RST;
            err <= 1'b0;
        end else if (wrap) begin
            act <= cand;
            err <= err | fault;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                    // R9
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        div_ok(act.div));                                                // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act));                                         // R4

endmodule

// File: rtl/fbdiv_count.sv
module fbdiv_count #(
    parameter int CW = fbdiv_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          wrap
);

    always_comb begin
        wrap    = (cnt == lim);
        cnt_nxt = wrap ? '0 : cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);                                                     // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));                                           // R1
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);                                                 // R1

endmodule

// File: rtl/fbdiv_sync.sv
module fbdiv_sync
    import fbdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  cfg_t             nxt,
    output logic             sync_q
);

    logic hit_rise, hit_fall, sync_d;

    always_comb begin
        hit_rise = (cnt_nxt == edge_pos(nxt.rise));
        hit_fall = (cnt_nxt == edge_pos(nxt.fall));
        if (!nxt.pen)      sync_d = 1'b0;
        else if (hit_rise) sync_d = 1'b1;
        else if (hit_fall) sync_d = 1'b0;
        else               sync_d = sync_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_d;
    end

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] div_set,
    input  logic [7:0]  rise_set,
    input  logic [7:0]  fall_set,
    output logic        tc_o,
    output logic        sync_o,
    output logic        err_o
);

    cfg_t             act, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             wrap;

    fbdiv_count #(.CW(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .lim     (act.div),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    fbdiv_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .div_in  (div_set),
        .rise_in (rise_set),
        .fall_in (fall_set),
        .act     (act),
        .nxt     (nxt),
        .err     (err_o)
    );

    fbdiv_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .nxt     (nxt),
        .sync_q  (sync_o)
    );

    assign tc_o = wrap;

    AST_SYNC_GATED: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> act.pen);                                             // R8
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> (cnt == edge_pos(act.rise)));                  // R5
    AST_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_o) && act.pen) |-> (cnt == edge_pos(act.fall)));     // R6

endmodule

// File: tb/tb_fbdiv_top.sv
module tb_fbdiv_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] div_set;
    logic [7:0]  rise_set, fall_set;
    logic        tc_o, sync_o, err_o;

    always #4 clk = ~clk;

    fbdiv_top dut (
        .clk      (clk),
        .rst      (rst),
        .div_set  (div_set),
        .rise_set (rise_set),
        .fall_set (fall_set),
        .tc_o     (tc_o),
        .sync_o   (sync_o),
        .err_o    (err_o)
    );

    int    vectors = 0;
    int    miscmp  = 0;
    string tag     = "R2";
    bit    live    = 0;
    bit    done    = 0;

    int m_cnt, m_div, m_rise, m_fall, nd, up;
    bit m_pen, m_sync, m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_div = 79; m_rise = 3; m_fall = 6;
            m_pen = 1; m_sync = 0; m_err = 0;
        end else begin
            if (m_cnt == m_div) begin
                if (int'(div_set) >= 63) nd = int'(div_set);
                else begin nd = m_div; m_err = 1; end
                up     = nd / 8;
                m_div  = nd;
                m_rise = int'(rise_set);
                m_fall = int'(fall_set);
                m_pen  = (m_rise < up) && (m_fall < up);
                if (!m_pen) m_err = 1;
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
            if (!m_pen)                    m_sync = 0;
            else if (m_cnt == m_rise * 8)  m_sync = 1;
            else if (m_cnt == m_fall * 8)  m_sync = 0;
        end
        live = 1;
    end

    task automatic check(input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            miscmp++;
            $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            check("tc_o",   tc_o,   m_cnt == m_div);
            check("sync_o", sync_o, m_sync);
            check("err_o",  err_o,  m_err);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int d, input int r, input int f);
        @(negedge clk);
        div_set  = 11'(d);
        rise_set = 8'(r);
        fall_set = 8'(f);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
    endtask

    task automatic measure_period(input int expect_len, input string req);
        int n;
        while (tc_o !== 1'b1) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tc_o !== 1'b1 && n < 5000);
        vectors++;
        if (n != expect_len) begin
            miscmp++;
            $display("FAIL %s period got %0d expected %0d", req, n, expect_len);
        end
    endtask

    initial begin
        int n;
        rst = 1'b1; div_set = 11'd100; rise_set = 8'd3; fall_set = 8'd6;
        run(4);
        // R2: reset state checked by the per-clock compare; strobe 79 clocks after release
        tag = "R2";
        vectors++;
        if (tc_o !== 1'b0 || sync_o !== 1'b0 || err_o !== 1'b0) begin
            miscmp++;
            $display("FAIL R2 reset outputs got %0b%0b%0b expected 000", tc_o, sync_o, err_o);
        end
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (tc_o !== 1'b1 && n < 500);
        vectors++;
        if (n != 79) begin
            miscmp++;
            $display("FAIL R2 first strobe got %0d expected 79", n);
        end
        run(300);

        tag = "R1";
        set_cfg(127, 2, 9);
        run(300);
        measure_period(128, "R1");
        run(100);

        tag = "R5";
        set_cfg(199, 5, 12);
        run(700);

        tag = "R4";
        for (int i = 0; i < 800; i++) begin
            int d, u;
            d = 63 + int'($urandom % 240);
            u = d / 8;
            set_cfg(d, int'($urandom) % u < 0 ? 0 : int'($urandom % u), int'($urandom % u));
        end
        set_cfg(150, 3, 9);
        run(400);

        tag = "R6";
        set_cfg(255, 20, 4);
        run(900);

        tag = "R7";
        set_cfg(150, 7, 7);
        run(500);

        tag = "R10";
        set_cfg(63, 1, 6);
        run(300);
        measure_period(64, "R10");
        set_cfg(2047, 254, 0);
        run(4300);
        measure_period(2048, "R10");

        tag = "R3";
        do_reset();
        set_cfg(10, 3, 6);
        run(300);
        measure_period(80, "R3");
        vectors++;
        if (err_o !== 1'b1) begin
            miscmp++;
            $display("FAIL R3 err_o got %0b expected 1", err_o);
        end

        tag = "R8";
        do_reset();
        set_cfg(100, 12, 2);
        run(400);

        tag = "R9";
        set_cfg(100, 3, 6);
        run(400);
        vectors++;
        if (err_o !== 1'b1) begin
            miscmp++;
            $display("FAIL R9 err_o got %0b expected 1", err_o);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscmp++;
            $display("FAIL watchdog expired in %s got hang expected completion", tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

endmodule